// File: doc/BRIEF.md
# Banked Host Register File for Three Card Channels

This block sits between an 8-bit host parallel bus (4-bit address, write strobe, read strobe, registered read data) and three identical card-interface channels. A single selection register holds a one-hot channel field and an interface-run bit. The channel field steers every access at the banked addresses to one channel's copy of that register. Several addresses alias, so that a read returns a status or receive value while a write reaches a separate control or transmit register. Some addresses are write-only and some are read-only.

Clearing the run bit holds the block in a partial reset. On every clock edge while the bit is low, each register is brought to a second reset value that keeps selected fields and forces the others. A full synchronous reset clears everything. Register contents, a 24-bit timeout load value with a one-cycle load strobe, and a transmit byte with a one-cycle strobe are driven to downstream logic. The UART, timers and power sequencing are outside this block and appear only as status inputs.

Top module: `hostreg_bank_top`

## Requirements
- R1: After full reset, address 0h reads 30h, both power-control copies hold 30h, and every other writable register holds 00h.
- R2: Select field values 001, 010 and 100 (bits 2:0 of address 0h) route reads and writes at 1h, 2h, 3h, 5h, 6h and 7h to channel 0, 1 and 2 respectively. Other channels' copies are untouched.
- R3: With any select value that is not one-hot, banked addresses read 00h and writes to them are ignored.
- R4: Address 7h exists only for channels 0 and 1. With channel 2 selected, it reads 00h and writes are ignored.
- R5: Unimplemented bits are dropped on write and read as 0. The implemented masks are 3Fh at 1h, 7Fh at 3h, DFh at 6h, 3Fh at 7h and 77h for the FIFO control. Bits 7:4 of address 0h always read 3h.
- R6: A read at Dh returns the receive-byte input. A write at Dh loads the transmit byte and pulses the transmit strobe for exactly one cycle.
- R7: A read at Ch returns the main status input, with bit 0 forced to 0 while the run bit is 0. A write at Ch loads the FIFO control register.
- R8: Addresses 9h, Ah and Bh are write-only and read 00h. A write at Bh latches {Bh data, Ah byte, 9h byte} as the 24-bit timeout value and pulses the load strobe for one cycle.
- R9: Eh and Fh are read-only. Eh returns the line status input, and Fh returns 0 in bit 7 over the hardware status input. Writes to them change no output.
- R10: A read of address 4h returns 00h.
- R11: While run (bit 3 of 0h) is 0, every edge applies the partial values. Channel control, divider, mode-2, guard and timeout staging and value are kept. Mode-1 keeps bits 6, 4, 1 and 0. Power control keeps bits 3:0 and sets bits 5:4. Timer config and the transmit byte clear. FIFO control keeps its implemented bits. Host writes to these registers are ignored, and address 0h stays writable.
- R12: Read data updates on the edge that samples the read strobe and holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full reset |
| bus_addr | input | 4 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Write strobe, one access per cycle high |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| rx_byte_i | input | 8 | Received byte from the UART |
| main_stat_i | input | 8 | Main status word |
| line_stat_i | input | 8 | UART line status word |
| hw_stat_i | input | 7 | Hardware and pin status |
| chan_sel_o | output | 3 | Current channel select field |
| iface_run_o | output | 1 | Run bit; 0 holds partial reset |
| ctl_o | output | 3x8 | Per-channel control register |
| pdiv_o | output | 3x8 | Per-channel clock divider |
| mode2_o | output | 3x8 | Per-channel mode register 2 |
| guard_o | output | 3x8 | Per-channel guard time |
| mode1_o | output | 3x8 | Per-channel mode register 1 |
| pwr_o | output | 2x8 | Power control, channels 0 and 1 |
| tmcfg_o | output | 8 | Timer configuration |
| tmo_value_o | output | 24 | Latched timeout load value |
| tmo_load_o | output | 1 | One-cycle timeout load strobe |
| fifo_ctl_o | output | 8 | FIFO control register |
| tx_byte_o | output | 8 | Transmit byte |
| tx_load_o | output | 1 | One-cycle transmit strobe |

## Verification
The assertions assume that the address, data and strobes hold defined values in every cycle after reset. They also assume that a write strobe covers a single cycle per access, so that each load strobe can be traced to one write. The stimulus drives each access for exactly one cycle from the falling edge and drops the strobes between accesses. It picks addresses across the whole map and biases selection writes toward a set run bit. Status inputs change only while a read is being set up, so they are stable at the sampling edge.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  localparam int DW        = 8;
  localparam int AW        = 4;
  localparam int TMO_BYTES = 3;
  localparam int TMO_W     = TMO_BYTES * DW;

  typedef enum logic [AW-1:0] {
    ADDR_SEL    = 4'h0,
    ADDR_CTL    = 4'h1,
    ADDR_PDIV   = 4'h2,
    ADDR_MODE2  = 4'h3,
    ADDR_GAP    = 4'h4,
    ADDR_GUARD  = 4'h5,
    ADDR_MODE1  = 4'h6,
    ADDR_PWR    = 4'h7,
    ADDR_TMCFG  = 4'h8,
    ADDR_TLD0   = 4'h9,
    ADDR_TLD1   = 4'hA,
    ADDR_TLD2   = 4'hB,
    ADDR_STFIFO = 4'hC,
    ADDR_DATA   = 4'hD,
    ADDR_LSTAT  = 4'hE,
    ADDR_HSTAT  = 4'hF
  } reg_addr_e;

  localparam logic [DW-1:0] SEL_ID     = 8'h30;
  localparam int            RUN_BIT    = 3;

  // write masks / partial-reset keep masks / partial-reset forced bits / full reset
  localparam logic [DW-1:0] CTL_WM   = 8'h3F, CTL_KP   = 8'h3F;
  localparam logic [DW-1:0] PDIV_WM  = 8'hFF, PDIV_KP  = 8'hFF;
  localparam logic [DW-1:0] MODE2_WM = 8'h7F, MODE2_KP = 8'h7F;
  localparam logic [DW-1:0] GUARD_WM = 8'hFF, GUARD_KP = 8'hFF;
  localparam logic [DW-1:0] MODE1_WM = 8'hDF, MODE1_KP = 8'h53;
  localparam logic [DW-1:0] PWR_WM   = 8'h3F, PWR_KP   = 8'h0F, PWR_FRC = 8'h30, PWR_RST = 8'h30;
  localparam logic [DW-1:0] TMCFG_WM = 8'hFF, TMCFG_KP = 8'h00;
  localparam logic [DW-1:0] TLD_WM   = 8'hFF, TLD_KP   = 8'hFF;
  localparam logic [DW-1:0] FIFO_WM  = 8'h77, FIFO_KP  = 8'h77;
  localparam logic [DW-1:0] TX_WM    = 8'hFF, TX_KP    = 8'h00;
endpackage

// File: rtl/hostreg_field.sv
module hostreg_field #(
  parameter int          W     = 8,
  parameter logic [W-1:0] WMASK = '1,
  parameter logic [W-1:0] KEEP  = '1,
  parameter logic [W-1:0] FORCE = '0,
  parameter logic [W-1:0] RSTV  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  // partial reset (run low) outranks host writes
  always_ff @(posedge clk) begin
    if (rst)       q <= RSTV;
    else if (!run) q <= (q & KEEP) | FORCE;
    else if (we)   q <= wdata & WMASK;
  end
endmodule

// File: rtl/hostreg_decode.sv
module hostreg_decode #(
  parameter int NCH = 3,
  parameter int AW  = 4
) (
  input  logic [AW-1:0]      addr,
  input  logic               wr,
  input  logic [NCH-1:0]     sel,
  output logic [(1<<AW)-1:0] we_vec,
  output logic [NCH-1:0]     bank_hit
);
  logic sel_ok;

  always_comb begin
    we_vec       = '0;
    we_vec[addr] = wr;
  end

  assign sel_ok   = (sel != '0) && ((sel & (sel - NCH'(1))) == '0);
  assign bank_hit = sel_ok ? sel : '0;
endmodule

// File: rtl/hostreg_chan.sv
module hostreg_chan
  import hostreg_pkg::*;
#(
  parameter bit HAS_PWR = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] wdata,
  input  logic          we_ctl,
  input  logic          we_pdiv,
  input  logic          we_mode2,
  input  logic          we_guard,
  input  logic          we_mode1,
  input  logic          we_pwr,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] pdiv_q,
  output logic [DW-1:0] mode2_q,
  output logic [DW-1:0] guard_q,
  output logic [DW-1:0] mode1_q,
  output logic [DW-1:0] pwr_q
);
  logic [DW-1:0] pwr_raw;

  hostreg_field #(.W(DW), .WMASK(CTL_WM), .KEEP(CTL_KP)) u_ctl (
    .clk(clk), .rst(rst), .run(run), .we(we_ctl), .wdata(wdata), .q(ctl_q));
  hostreg_field #(.W(DW), .WMASK(PDIV_WM), .KEEP(PDIV_KP)) u_pdiv (
    .clk(clk), .rst(rst), .run(run), .we(we_pdiv), .wdata(wdata), .q(pdiv_q));
  hostreg_field #(.W(DW), .WMASK(MODE2_WM), .KEEP(MODE2_KP)) u_mode2 (
    .clk(clk), .rst(rst), .run(run), .we(we_mode2), .wdata(wdata), .q(mode2_q));
  hostreg_field #(.W(DW), .WMASK(GUARD_WM), .KEEP(GUARD_KP)) u_guard (
    .clk(clk), .rst(rst), .run(run), .we(we_guard), .wdata(wdata), .q(guard_q));
  hostreg_field #(.W(DW), .WMASK(MODE1_WM), .KEEP(MODE1_KP)) u_mode1 (
    .clk(clk), .rst(rst), .run(run), .we(we_mode1), .wdata(wdata), .q(mode1_q));
  hostreg_field #(.W(DW), .WMASK(PWR_WM), .KEEP(PWR_KP), .FORCE(PWR_FRC), .RSTV(PWR_RST)) u_pwr (
    .clk(clk), .rst(rst), .run(run), .we(we_pwr && HAS_PWR), .wdata(wdata), .q(pwr_raw));

  // channels without power control read zero there (R4)
  assign pwr_q = HAS_PWR ? pwr_raw : '0;
endmodule

// File: rtl/hostreg_common.sv
module hostreg_common
  import hostreg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [DW-1:0]        wdata,
  input  logic                 we_tmcfg,
  input  logic [TMO_BYTES-1:0] we_tld,
  input  logic                 we_fifo,
  input  logic                 we_tx,
  output logic [DW-1:0]        tmcfg_q,
  output logic [TMO_W-1:0]     tmo_value_q,
  output logic                 tmo_load_q,
  output logic [DW-1:0]        fifo_q,
  output logic [DW-1:0]        tx_q,
  output logic                 tx_load_q
);
  logic [TMO_BYTES-2:0][DW-1:0] stage;

  hostreg_field #(.W(DW), .WMASK(TMCFG_WM), .KEEP(TMCFG_KP)) u_tmcfg (
    .clk(clk), .rst(rst), .run(run), .we(we_tmcfg), .wdata(wdata), .q(tmcfg_q));
  hostreg_field #(.W(DW), .WMASK(FIFO_WM), .KEEP(FIFO_KP)) u_fifo (
    .clk(clk), .rst(rst), .run(run), .we(we_fifo), .wdata(wdata), .q(fifo_q));
  hostreg_field #(.W(DW), .WMASK(TX_WM), .KEEP(TX_KP)) u_tx (
    .clk(clk), .rst(rst), .run(run), .we(we_tx), .wdata(wdata), .q(tx_q));

  // lower timeout bytes are staged; the top byte commits all of them at once
  for (genvar b = 0; b < TMO_BYTES-1; b++) begin : g_stage
    hostreg_field #(.W(DW), .WMASK(TLD_WM), .KEEP(TLD_KP)) u_tld (
      .clk(clk), .rst(rst), .run(run), .we(we_tld[b]), .wdata(wdata), .q(stage[b]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_value_q <= '0;
      tmo_load_q  <= 1'b0;
      tx_load_q   <= 1'b0;
    end else begin
      tmo_load_q <= run && we_tld[TMO_BYTES-1];
      tx_load_q  <= run && we_tx;
      if (run && we_tld[TMO_BYTES-1])
        tmo_value_q <= {wdata, stage};
    end
  end
endmodule

// File: rtl/hostreg_bank_top.sv
module hostreg_bank_top
  import hostreg_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int PWR_CH = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  output logic [DW-1:0]            bus_rdata,
  input  logic [DW-1:0]            rx_byte_i,
  input  logic [DW-1:0]            main_stat_i,
  input  logic [DW-1:0]            line_stat_i,
  input  logic [DW-2:0]            hw_stat_i,
  output logic [NCH-1:0]           chan_sel_o,
  output logic                     iface_run_o,
  output logic [NCH-1:0][DW-1:0]   ctl_o,
  output logic [NCH-1:0][DW-1:0]   pdiv_o,
  output logic [NCH-1:0][DW-1:0]   mode2_o,
  output logic [NCH-1:0][DW-1:0]   guard_o,
  output logic [NCH-1:0][DW-1:0]   mode1_o,
  output logic [PWR_CH-1:0][DW-1:0] pwr_o,
  output logic [DW-1:0]            tmcfg_o,
  output logic [TMO_W-1:0]         tmo_value_o,
  output logic                     tmo_load_o,
  output logic [DW-1:0]            fifo_ctl_o,
  output logic [DW-1:0]            tx_byte_o,
  output logic                     tx_load_o
);
  localparam int NADDR = 1 << AW;

  logic [NADDR-1:0]        we_vec;
  logic [NCH-1:0]          bank_hit;
  logic [NCH-1:0]          sel_q;
  logic                    run_q;
  logic [NCH-1:0][DW-1:0]  ch_pwr;
  logic [DW-1:0]           rd_next;
  logic [DW-1:0]           bk_ctl, bk_pdiv, bk_mode2, bk_guard, bk_mode1, bk_pwr;

  hostreg_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .sel(sel_q), .we_vec(we_vec), .bank_hit(bank_hit));

  // selection register: always writable, untouched by partial reset
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      run_q <= 1'b0;
    end else if (we_vec[ADDR_SEL]) begin
      sel_q <= bus_wdata[NCH-1:0];
      run_q <= bus_wdata[RUN_BIT];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hostreg_chan #(.HAS_PWR(c < PWR_CH)) u_ch (
      .clk(clk), .rst(rst), .run(run_q), .wdata(bus_wdata),
      .we_ctl  (we_vec[ADDR_CTL]   && bank_hit[c]),
      .we_pdiv (we_vec[ADDR_PDIV]  && bank_hit[c]),
      .we_mode2(we_vec[ADDR_MODE2] && bank_hit[c]),
      .we_guard(we_vec[ADDR_GUARD] && bank_hit[c]),
      .we_mode1(we_vec[ADDR_MODE1] && bank_hit[c]),
      .we_pwr  (we_vec[ADDR_PWR]   && bank_hit[c]),
      .ctl_q(ctl_o[c]), .pdiv_q(pdiv_o[c]), .mode2_q(mode2_o[c]),
      .guard_q(guard_o[c]), .mode1_q(mode1_o[c]), .pwr_q(ch_pwr[c]));
    if (c < PWR_CH) begin : g_pwr_out
      assign pwr_o[c] = ch_pwr[c];
    end
  end

  hostreg_common u_com (
    .clk(clk), .rst(rst), .run(run_q), .wdata(bus_wdata),
    .we_tmcfg(we_vec[ADDR_TMCFG]),
    .we_tld  ({we_vec[ADDR_TLD2], we_vec[ADDR_TLD1], we_vec[ADDR_TLD0]}),
    .we_fifo (we_vec[ADDR_STFIFO]),
    .we_tx   (we_vec[ADDR_DATA]),
    .tmcfg_q(tmcfg_o), .tmo_value_q(tmo_value_o), .tmo_load_q(tmo_load_o),
    .fifo_q(fifo_ctl_o), .tx_q(tx_byte_o), .tx_load_q(tx_load_o));

  // banked read: OR of the one selected copy, zero when no valid channel
  always_comb begin
    bk_ctl = '0; bk_pdiv = '0; bk_mode2 = '0; bk_guard = '0; bk_mode1 = '0; bk_pwr = '0;
    for (int c = 0; c < NCH; c++) begin
      if (bank_hit[c]) begin
        bk_ctl   = bk_ctl   | ctl_o[c];
        bk_pdiv  = bk_pdiv  | pdiv_o[c];
        bk_mode2 = bk_mode2 | mode2_o[c];
        bk_guard = bk_guard | guard_o[c];
        bk_mode1 = bk_mode1 | mode1_o[c];
        bk_pwr   = bk_pwr   | ch_pwr[c];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_SEL:    rd_next = SEL_ID | (DW'(run_q) << RUN_BIT) | DW'(sel_q);
      ADDR_CTL:    rd_next = bk_ctl;
      ADDR_PDIV:   rd_next = bk_pdiv;
      ADDR_MODE2:  rd_next = bk_mode2;
      ADDR_GUARD:  rd_next = bk_guard;
      ADDR_MODE1:  rd_next = bk_mode1;
      ADDR_PWR:    rd_next = bk_pwr;
      ADDR_TMCFG:  rd_next = tmcfg_o;
      ADDR_STFIFO: rd_next = {main_stat_i[DW-1:1], main_stat_i[0] & run_q};
      ADDR_DATA:   rd_next = rx_byte_i;
      ADDR_LSTAT:  rd_next = line_stat_i;
      ADDR_HSTAT:  rd_next = {1'b0, hw_stat_i};
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign chan_sel_o  = sel_q;
  assign iface_run_o = run_q;
endmodule

// File: rtl/hostreg_bank_chk.sv
module hostreg_bank_chk #(
  parameter int NCH    = 3,
  parameter int PWR_CH = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic [3:0]               bus_addr,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic [7:0]               bus_rdata,
  input logic                     iface_run_o,
  input logic [NCH-1:0]           bank_hit,
  input logic [PWR_CH-1:0][7:0]   pwr_o,
  input logic [7:0]               tmcfg_o,
  input logic                     tmo_load_o,
  input logic                     tx_load_o
);
  p_bank_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_hit));

  p_sel_id_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 4'h0) |=> (bus_rdata[7:4] == 4'h3));

  p_gap_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 4'h4) |=> (bus_rdata == 8'h00));

  p_wonly_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == 4'h9 || bus_addr == 4'hA || bus_addr == 4'hB)) |=> (bus_rdata == 8'h00));

  p_load_cause_r8: assert property (@(posedge clk) disable iff (rst)
    tmo_load_o |-> $past(bus_wr && bus_addr == 4'hB && iface_run_o));

  p_tx_cause_r6: assert property (@(posedge clk) disable iff (rst)
    tx_load_o |-> $past(bus_wr && bus_addr == 4'hD && iface_run_o));

  p_hstat_top_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 4'hF) |=> (bus_rdata[7] == 1'b0));

  p_pwr_forced_r11: assert property (@(posedge clk) disable iff (rst)
    !iface_run_o |=> (pwr_o[0][5:4] == 2'b11));

  p_tmcfg_clear_r11: assert property (@(posedge clk) disable iff (rst)
    !iface_run_o |=> (tmcfg_o == 8'h00));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind hostreg_bank_top hostreg_bank_chk #(.NCH(NCH), .PWR_CH(PWR_CH)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .iface_run_o(iface_run_o), .bank_hit(bank_hit),
  .pwr_o(pwr_o), .tmcfg_o(tmcfg_o), .tmo_load_o(tmo_load_o), .tx_load_o(tx_load_o));

// File: tb/hostreg_bank_top_tb_top.sv
module hostreg_bank_top_tb_top;
  localparam int NCH = 3, PWR_CH = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] rx_byte_i = '0, main_stat_i = '0, line_stat_i = '0;
  logic [6:0] hw_stat_i = '0;
  logic [NCH-1:0] chan_sel_o;
  logic iface_run_o;
  logic [NCH-1:0][7:0] ctl_o, pdiv_o, mode2_o, guard_o, mode1_o;
  logic [PWR_CH-1:0][7:0] pwr_o;
  logic [7:0] tmcfg_o, fifo_ctl_o, tx_byte_o;
  logic [23:0] tmo_value_o;
  logic tmo_load_o, tx_load_o;

  hostreg_bank_top #(.NCH(NCH), .PWR_CH(PWR_CH)) dut_i (.*);

  int checks = 0, failures = 0;

  // reference state
  logic [7:0] m_ctl[NCH], m_pdiv[NCH], m_mode2[NCH], m_guard[NCH], m_mode1[NCH], m_pwr[NCH];
  logic [2:0] m_sel;
  logic       m_run;
  logic [7:0] m_tmcfg, m_tld0, m_tld1, m_fifo, m_tx;
  logic [23:0] m_tmo;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int chan_of(logic [2:0] s);
    case (s)
      3'b001: return 0;
      3'b010: return 1;
      3'b100: return 2;
      default: return -1;
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_ctl[c] = 0; m_pdiv[c] = 0; m_mode2[c] = 0; m_guard[c] = 0; m_mode1[c] = 0; m_pwr[c] = 8'h30;
    end
    m_sel = 0; m_run = 0; m_tmcfg = 0; m_tld0 = 0; m_tld1 = 0; m_fifo = 0; m_tx = 0; m_tmo = 0;
  endtask

  // R11 partial values
  task automatic model_partial();
    for (int c = 0; c < NCH; c++) begin
      m_mode1[c] = m_mode1[c] & 8'h53;
      m_pwr[c]   = (m_pwr[c] & 8'h0F) | 8'h30;
    end
    m_tmcfg = 0; m_tx = 0; m_fifo = m_fifo & 8'h77;
  endtask

  function automatic logic [7:0] exp_read(logic [3:0] a);
    int c = chan_of(m_sel);
    case (a)
      4'h0: return {4'h3, m_run, m_sel};
      4'h1: return (c < 0) ? 8'h00 : m_ctl[c];
      4'h2: return (c < 0) ? 8'h00 : m_pdiv[c];
      4'h3: return (c < 0) ? 8'h00 : m_mode2[c];
      4'h5: return (c < 0) ? 8'h00 : m_guard[c];
      4'h6: return (c < 0) ? 8'h00 : m_mode1[c];
      4'h7: return (c < 0 || c >= PWR_CH) ? 8'h00 : m_pwr[c];
      4'h8: return m_tmcfg;
      4'hC: return {main_stat_i[7:1], main_stat_i[0] & m_run};
      4'hD: return rx_byte_i;
      4'hE: return line_stat_i;
      4'hF: return {1'b0, hw_stat_i};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk_outputs(string tag);
    for (int c = 0; c < NCH; c++) begin
      chk({tag, " ctl"},   ctl_o[c],   m_ctl[c]);
      chk({tag, " pdiv"},  pdiv_o[c],  m_pdiv[c]);
      chk({tag, " mode2"}, mode2_o[c], m_mode2[c]);
      chk({tag, " guard"}, guard_o[c], m_guard[c]);
      chk({tag, " mode1"}, mode1_o[c], m_mode1[c]);
      if (c < PWR_CH) chk({tag, " pwr"}, pwr_o[c], m_pwr[c]);
    end
    chk({tag, " tmcfg"}, tmcfg_o, m_tmcfg);
    chk({tag, " fifo"},  fifo_ctl_o, m_fifo);
    chk({tag, " tx"},    tx_byte_o, m_tx);
    chk({tag, " tmo"},   tmo_value_o, m_tmo);
    chk({tag, " sel"},   {iface_run_o, chan_sel_o}, {m_run, m_sel});
  endtask

  task automatic do_write(logic [3:0] a, logic [7:0] d, string tag);
    logic prev_run;
    int c;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    prev_run = m_run;
    c = chan_of(m_sel);
    if (!prev_run) model_partial();
    else begin
      case (a)
        4'h1: if (c >= 0) m_ctl[c]   = d & 8'h3F;
        4'h2: if (c >= 0) m_pdiv[c]  = d;
        4'h3: if (c >= 0) m_mode2[c] = d & 8'h7F;
        4'h5: if (c >= 0) m_guard[c] = d;
        4'h6: if (c >= 0) m_mode1[c] = d & 8'hDF;
        4'h7: if (c >= 0 && c < PWR_CH) m_pwr[c] = d & 8'h3F;
        4'h8: m_tmcfg = d;
        4'h9: m_tld0 = d;
        4'hA: m_tld1 = d;
        4'hB: m_tmo = {d, m_tld1, m_tld0};
        4'hC: m_fifo = d & 8'h77;
        4'hD: m_tx = d;
        default: ;
      endcase
    end
    if (a == 4'h0) begin m_run = d[3]; m_sel = d[2:0]; end
    chk({tag, " R8 load strobe"}, tmo_load_o, prev_run && a == 4'hB);
    chk({tag, " R6 tx strobe"},   tx_load_o,  prev_run && a == 4'hD);
    chk_outputs(tag);
  endtask

  task automatic do_read(logic [3:0] a, string tag);
    logic [7:0] e;
    @(negedge clk);
    rx_byte_i = 8'($urandom); main_stat_i = 8'($urandom);
    line_stat_i = 8'($urandom); hw_stat_i = 7'($urandom);
    bus_addr = a; bus_rd = 1'b1;
    e = exp_read(a);
    @(negedge clk);
    bus_rd = 1'b0;
    if (!m_run) model_partial();
    chk(tag, bus_rdata, e);
  endtask

  task automatic do_idle(string tag);
    logic [7:0] held;
    held = bus_rdata;
    @(negedge clk);
    if (!m_run) model_partial();
    chk({tag, " R12 hold"}, bus_rdata, held);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0C0D));
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    if (!m_run) model_partial();

    // R1 reset state
    chk_outputs("R1 reset");
    do_read(4'h0, "R1 sel reads 30h");
    chk("R1 literal", bus_rdata, 8'h30);

    // R11 writes ignored while run=0
    do_write(4'h8, 8'hAA, "R11 ignored write");
    chk("R11 tmcfg stays 0", tmcfg_o, 8'h00);

    // R2 / R5 banked access, masks
    do_write(4'h0, 8'h09, "R2 select ch0");
    do_write(4'h1, 8'hFF, "R5 ctl mask");
    do_read(4'h1, "R5 ctl reads 3Fh");
    chk("R5 literal", bus_rdata, 8'h3F);
    do_write(4'h6, 8'hFF, "R5 mode1 mask");
    do_write(4'h3, 8'hFF, "R5 mode2 mask");
    do_write(4'h0, 8'h0A, "R2 select ch1");
    do_write(4'h1, 8'h15, "R2 ch1 ctl");
    do_read(4'h1, "R2 ch1 ctl readback");
    do_write(4'h0, 8'hF9, "R5 upper sel bits ignored");
    do_read(4'h0, "R5 sel id");
    do_read(4'h1, "R2 ch0 ctl untouched");
    chk("R2 ch0 literal", bus_rdata, 8'h3F);

    // R3 invalid select
    do_write(4'h0, 8'h0B, "R3 select 011");
    do_read(4'h1, "R3 banked read zero");
    do_write(4'h2, 8'h77, "R3 write ignored");
    do_write(4'h0, 8'h08, "R3 select 000");
    do_read(4'h5, "R3 banked read zero sel0");

    // R4 power control only ch0/ch1
    do_write(4'h0, 8'h0C, "R4 select ch2");
    do_write(4'h7, 8'h07, "R4 ch2 pwr write ignored");
    do_read(4'h7, "R4 ch2 pwr reads 0");
    do_write(4'h0, 8'h09, "R4 select ch0");
    do_write(4'h7, 8'hFF, "R4 ch0 pwr");
    do_read(4'h7, "R4 ch0 pwr reads 3Fh");

    // R8 timeout
    do_write(4'h9, 8'h11, "R8 tld0");
    do_write(4'hA, 8'h22, "R8 tld1");
    do_write(4'hB, 8'h33, "R8 tld2");
    chk("R8 value", tmo_value_o, 24'h332211);
    do_idle("R8 strobe drop");
    chk("R8 strobe one cycle", tmo_load_o, 1'b0);
    do_read(4'h9, "R8 wonly 9");
    do_read(4'hA, "R8 wonly A");
    do_read(4'hB, "R8 wonly B");

    // R6 / R7 aliased addresses
    do_write(4'hD, 8'hC5, "R6 tx write");
    do_idle("R6 strobe drop");
    chk("R6 strobe one cycle", tx_load_o, 1'b0);
    do_read(4'hD, "R6 rx read");
    do_write(4'hC, 8'hFF, "R7 fifo write");
    chk("R7 fifo literal", fifo_ctl_o, 8'h77);
    do_read(4'hC, "R7 status read run");

    // R9 / R10
    do_write(4'hE, 8'hFF, "R9 lstat write ignored");
    do_write(4'hF, 8'hFF, "R9 hstat write ignored");
    do_read(4'hE, "R9 lstat read");
    do_read(4'hF, "R9 hstat read");
    do_read(4'h4, "R10 gap read");
    do_write(4'h4, 8'hFF, "R10 gap write");

    // R11 partial reset
    do_write(4'h8, 8'h5A, "R11 tmcfg set");
    do_write(4'h6, 8'hFF, "R11 mode1 set");
    do_write(4'h0, 8'h01, "R11 run low");
    do_idle("R11 partial apply");
    chk_outputs("R11 partial");
    chk("R11 mode1 literal", mode1_o[0], 8'h53);
    do_read(4'hC, "R7 status bit0 cleared");
    do_write(4'h5, 8'h99, "R11 guard write ignored");
    do_write(4'hB, 8'h44, "R11 tmo write ignored");
    do_write(4'h0, 8'h09, "R11 run high");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a = 4'($urandom);
      logic [7:0] d = 8'($urandom);
      if (a == 4'h0) begin
        d[3] = ($urandom % 5) != 0;
        case ($urandom % 4)
          0: d[2:0] = 3'b001;
          1: d[2:0] = 3'b010;
          2: d[2:0] = 3'b100;
          default: ;
        endcase
      end
      case ($urandom % 3)
        0: do_write(a, d, "R2 random write");
        1: do_read(a, "R2 random read");
        default: begin
          do_read(a, "R12 random read");
          do_idle("R12 random idle");
        end
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule